// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Register File

This block collects completion events from up to eight transmit and eight receive DMA channels, plus a host-error event, and turns them into one level interrupt for the processor. Each source has a raw status bit and an enable bit. A pulse from a channel engine sets its raw bit. An acknowledge from the same engine clears it, which happens when software acknowledges the channel's completion pointer.

Software changes the enables without a read-modify-write. Each group has one address where ones set enable bits and another where ones clear them. Raw status and masked status can be read separately. A vector register shows every masked source in one word. Writing the end-of-interrupt register drops the interrupt line for one cycle, so that a downstream edge-sensitive controller sees a fresh edge if work is still pending.

The register port is a simple strobe interface. A read returns its data one cycle after the read strobe.

Top module: `irqmu_top`

## Requirements
- R1: After reset, every raw bit and every enable bit is zero, `irq` is low and `rd_data` is zero.
- R2: A pulse on channel i of `tx_done` sets bit i of the transmit raw word at 0x80. A pulse on channel i of `rx_done` sets bit i of the receive raw word at 0xA0. A pulse on `host_err` sets bit 1 of the error raw word at 0xB0.
- R3: A pulse on an acknowledge input clears the matching raw bit. If an event and an acknowledge reach the same bit in the same cycle, the bit ends up set.
- R4: A write to a mask-set address (0x88 transmit, 0xA8 receive, 0xB8 error) sets the enable bits written as one. Bits written as zero keep their value.
- R5: A write to a mask-clear address (0x8C, 0xAC, 0xBC) clears the enable bits written as one and keeps the rest. Writing 0xFFFFFFFF disables the whole group.
- R6: The masked words at 0x84, 0xA4 and 0xB4 read as raw AND enable. Reading a mask-set or mask-clear address returns that group's enable word.
- R7: The vector word at 0x90 holds the masked status in three fields: transmit in bits 7:0, receive in bits 15:8, and error in bits 17:16.
- R8: `irq` rises one cycle after the state holds any masked bit. It stays high while any masked bit remains set, and falls one cycle after the last one goes away.
- R9: A write of any value to 0x94 forces `irq` low in the following cycle. On the next cycle, `irq` goes high again if a masked bit is still set.
- R10: Read data appears on `rd_data` in the cycle after `rd_en`. A read of an unmapped address returns zero. A write to a read-only or unmapped address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| tx_done | input | NUM_TX (8) | Per-channel transmit completion pulses |
| tx_ack | input | NUM_TX (8) | Per-channel transmit completion acknowledge |
| rx_done | input | NUM_RX (8) | Per-channel receive completion pulses |
| rx_ack | input | NUM_RX (8) | Per-channel receive completion acknowledge |
| host_err | input | 1 | Host error event pulse |
| host_err_ack | input | 1 | Host error acknowledge |
| irq | output | 1 | Combined level interrupt |

## Verification
Faults in this block show up at the ports quickly and in predictable places:

- **Wrong raw bit:** it appears on the next read of the raw, masked or vector word, and it can also leave `irq` wrong two cycles after the event.
- **Wrong enable bit:** it appears on the next read of either mask address, and it changes `irq` whenever the matching raw bit is set.
- **Broken end-of-interrupt handling:** it appears within two cycles of the 0x94 write. Either the one-cycle low is missing, or `irq` fails to recover.

Because a random sequence keeps an independent model of all three groups and compares every read against it, a corrupted bit shows up within a few operations.

// File: rtl/irqmu_pkg.sv
package irqmu_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_TX_RAW  = 8'h80;
  localparam logic [ADDR_W-1:0] A_TX_MSK  = 8'h84;
  localparam logic [ADDR_W-1:0] A_TX_SET  = 8'h88;
  localparam logic [ADDR_W-1:0] A_TX_CLR  = 8'h8C;
  localparam logic [ADDR_W-1:0] A_VECTOR  = 8'h90;
  localparam logic [ADDR_W-1:0] A_EOI     = 8'h94;
  localparam logic [ADDR_W-1:0] A_RX_RAW  = 8'hA0;
  localparam logic [ADDR_W-1:0] A_RX_MSK  = 8'hA4;
  localparam logic [ADDR_W-1:0] A_RX_SET  = 8'hA8;
  localparam logic [ADDR_W-1:0] A_RX_CLR  = 8'hAC;
  localparam logic [ADDR_W-1:0] A_ER_RAW  = 8'hB0;
  localparam logic [ADDR_W-1:0] A_ER_MSK  = 8'hB4;
  localparam logic [ADDR_W-1:0] A_ER_SET  = 8'hB8;
  localparam logic [ADDR_W-1:0] A_ER_CLR  = 8'hBC;

  localparam int ERR_W        = 2;
  localparam int HOST_ERR_BIT = 1;

  localparam int VEC_TX_LSB = 0;
  localparam int VEC_RX_LSB = 8;
  localparam int VEC_ER_LSB = 16;
endpackage

// File: rtl/irqmu_group.sv
module irqmu_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ack,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] raw,
  output logic [W-1:0] enable,
  output logic [W-1:0] masked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
    end else begin
      raw <= (raw & ~ack) | evt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
    end else if (set_we) begin
      enable <= enable | wbits;
    end else if (clr_we) begin
      enable <= enable & ~wbits;
    end
  end

  assign masked = raw & enable;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((raw & $past(evt)) == $past(evt))); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|(ack & ~evt)) |=> ((raw & $past(ack & ~evt)) == '0)); // R3
  AST_SET_ONES: assert property (@(posedge clk) disable iff (rst)
    set_we |=> (((enable & $past(wbits)) == $past(wbits)) &&
                ((enable & ~$past(wbits)) == ($past(enable) & ~$past(wbits))))); // R4
  AST_CLR_ONES: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> (((enable & $past(wbits)) == '0) &&
                ((enable & ~$past(wbits)) == ($past(enable) & ~$past(wbits))))); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(enable)); // R10
endmodule

// File: rtl/irqmu_regif.sv
module irqmu_regif
  import irqmu_pkg::*;
#(
  parameter int NUM_TX = 8,
  parameter int NUM_RX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_TX-1:0] tx_raw,
  input  logic [NUM_TX-1:0] tx_en,
  input  logic [NUM_TX-1:0] tx_msk,
  input  logic [NUM_RX-1:0] rx_raw,
  input  logic [NUM_RX-1:0] rx_en,
  input  logic [NUM_RX-1:0] rx_msk,
  input  logic [ERR_W-1:0]  er_raw,
  input  logic [ERR_W-1:0]  er_en,
  input  logic [ERR_W-1:0]  er_msk,
  output logic              tx_set_we,
  output logic              tx_clr_we,
  output logic              rx_set_we,
  output logic              rx_clr_we,
  output logic              er_set_we,
  output logic              er_clr_we,
  output logic              eoi_we,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] vec;

  assign tx_set_we = wr_en && (addr == A_TX_SET);
  assign tx_clr_we = wr_en && (addr == A_TX_CLR);
  assign rx_set_we = wr_en && (addr == A_RX_SET);
  assign rx_clr_we = wr_en && (addr == A_RX_CLR);
  assign er_set_we = wr_en && (addr == A_ER_SET);
  assign er_clr_we = wr_en && (addr == A_ER_CLR);
  assign eoi_we    = wr_en && (addr == A_EOI);

  always_comb begin
    vec = '0;
    vec[VEC_TX_LSB +: NUM_TX] = tx_msk;
    vec[VEC_RX_LSB +: NUM_RX] = rx_msk;
    vec[VEC_ER_LSB +: ERR_W]  = er_msk;
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      A_TX_RAW:           rd_next[NUM_TX-1:0] = tx_raw;
      A_TX_MSK:           rd_next[NUM_TX-1:0] = tx_msk;
      A_TX_SET, A_TX_CLR: rd_next[NUM_TX-1:0] = tx_en;
      A_RX_RAW:           rd_next[NUM_RX-1:0] = rx_raw;
      A_RX_MSK:           rd_next[NUM_RX-1:0] = rx_msk;
      A_RX_SET, A_RX_CLR: rd_next[NUM_RX-1:0] = rx_en;
      A_ER_RAW:           rd_next[ERR_W-1:0]  = er_raw;
      A_ER_MSK:           rd_next[ERR_W-1:0]  = er_msk;
      A_ER_SET, A_ER_CLR: rd_next[ERR_W-1:0]  = er_en;
      A_VECTOR:           rd_next = vec;
      default:            rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $countones({tx_set_we, tx_clr_we, rx_set_we, rx_clr_we,
                er_set_we, er_clr_we, eoi_we}) <= 1); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R10
endmodule

// File: rtl/irqmu_top.sv
module irqmu_top
  import irqmu_pkg::*;
#(
  parameter int NUM_TX = 8,
  parameter int NUM_RX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [NUM_TX-1:0] tx_done,
  input  logic [NUM_TX-1:0] tx_ack,
  input  logic [NUM_RX-1:0] rx_done,
  input  logic [NUM_RX-1:0] rx_ack,
  input  logic              host_err,
  input  logic              host_err_ack,
  output logic              irq
);
  logic [NUM_TX-1:0] tx_raw, tx_en, tx_msk;
  logic [NUM_RX-1:0] rx_raw, rx_en, rx_msk;
  logic [ERR_W-1:0]  er_raw, er_en, er_msk;
  logic [ERR_W-1:0]  er_evt, er_ack;
  logic tx_set_we, tx_clr_we, rx_set_we, rx_clr_we, er_set_we, er_clr_we, eoi_we;
  logic any_pending;

  always_comb begin
    er_evt = '0;
    er_ack = '0;
    er_evt[HOST_ERR_BIT] = host_err;
    er_ack[HOST_ERR_BIT] = host_err_ack;
  end

  irqmu_group #(.W(NUM_TX)) u_tx (
    .clk(clk), .rst(rst), .evt(tx_done), .ack(tx_ack),
    .set_we(tx_set_we), .clr_we(tx_clr_we), .wbits(wr_data[NUM_TX-1:0]),
    .raw(tx_raw), .enable(tx_en), .masked(tx_msk));

  irqmu_group #(.W(NUM_RX)) u_rx (
    .clk(clk), .rst(rst), .evt(rx_done), .ack(rx_ack),
    .set_we(rx_set_we), .clr_we(rx_clr_we), .wbits(wr_data[NUM_RX-1:0]),
    .raw(rx_raw), .enable(rx_en), .masked(rx_msk));

  irqmu_group #(.W(ERR_W)) u_er (
    .clk(clk), .rst(rst), .evt(er_evt), .ack(er_ack),
    .set_we(er_set_we), .clr_we(er_clr_we), .wbits(wr_data[ERR_W-1:0]),
    .raw(er_raw), .enable(er_en), .masked(er_msk));

  irqmu_regif #(.NUM_TX(NUM_TX), .NUM_RX(NUM_RX)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .tx_raw(tx_raw), .tx_en(tx_en), .tx_msk(tx_msk),
    .rx_raw(rx_raw), .rx_en(rx_en), .rx_msk(rx_msk),
    .er_raw(er_raw), .er_en(er_en), .er_msk(er_msk),
    .tx_set_we(tx_set_we), .tx_clr_we(tx_clr_we),
    .rx_set_we(rx_set_we), .rx_clr_we(rx_clr_we),
    .er_set_we(er_set_we), .er_clr_we(er_clr_we),
    .eoi_we(eoi_we), .rd_data(rd_data));

  assign any_pending = (|tx_msk) | (|rx_msk) | (|er_msk);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= any_pending & ~eoi_we;
    end
  end

  AST_EOI_DROP: assert property (@(posedge clk) disable iff (rst)
    eoi_we |=> !irq); // R9
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (any_pending && !eoi_we) |=> irq); // R8
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !any_pending |=> !irq); // R8
endmodule

// File: tb/irqmu_top_tb_top.sv
module irqmu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [7:0]  tx_done, tx_ack, rx_done, rx_ack;
  logic        host_err, host_err_ack;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [7:0] m_txr, m_txe, m_rxr, m_rxe;
  logic [1:0] m_err, m_ere;

  always #2 clk = ~clk;

  irqmu_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .tx_done(tx_done), .tx_ack(tx_ack),
    .rx_done(rx_done), .rx_ack(rx_ack), .host_err(host_err),
    .host_err_ack(host_err_ack), .irq(irq));

  function automatic logic exp_irq();
    return |(m_txr & m_txe) | |(m_rxr & m_rxe) | |(m_err & m_ere);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] v = '0;
    case (a)
      8'h80: v[7:0] = m_txr;
      8'h84: v[7:0] = m_txr & m_txe;
      8'h88, 8'h8C: v[7:0] = m_txe;
      8'hA0: v[7:0] = m_rxr;
      8'hA4: v[7:0] = m_rxr & m_rxe;
      8'hA8, 8'hAC: v[7:0] = m_rxe;
      8'hB0: v[1:0] = m_err;
      8'hB4: v[1:0] = m_err & m_ere;
      8'hB8, 8'hBC: v[1:0] = m_ere;
      8'h90: begin
        v[7:0] = m_txr & m_txe;
        v[15:8] = m_rxr & m_rxe;
        v[17:16] = m_err & m_ere;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0; tx_done = 0; tx_ack = 0; rx_done = 0; rx_ack = 0;
    host_err = 0; host_err_ack = 0;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      8'h88: m_txe = m_txe | d[7:0];
      8'h8C: m_txe = m_txe & ~d[7:0];
      8'hA8: m_rxe = m_rxe | d[7:0];
      8'hAC: m_rxe = m_rxe & ~d[7:0];
      8'hB8: m_ere = m_ere | d[1:0];
      8'hBC: m_ere = m_ere & ~d[1:0];
      default: ;
    endcase
  endtask

  task automatic reg_check(input string req, input logic [7:0] a);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    check(req, rd_data, exp_read(a));
  endtask

  task automatic events(input logic [7:0] td, input logic [7:0] ta,
                        input logic [7:0] rd, input logic [7:0] ra,
                        input logic he, input logic ha);
    @(negedge clk);
    tx_done = td; tx_ack = ta; rx_done = rd; rx_ack = ra;
    host_err = he; host_err_ack = ha;
    @(negedge clk);
    tx_done = 0; tx_ack = 0; rx_done = 0; rx_ack = 0; host_err = 0; host_err_ack = 0;
    m_txr = (m_txr & ~ta) | td;
    m_rxr = (m_rxr & ~ra) | rd;
    m_err = (m_err & ~{ha, 1'b0}) | {he, 1'b0};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra;
    void'($urandom(32'd1234));
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
    tx_done = 0; tx_ack = 0; rx_done = 0; rx_ack = 0; host_err = 0; host_err_ack = 0;
    m_txr = 0; m_txe = 0; m_rxr = 0; m_rxe = 0; m_err = 0; m_ere = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    reg_check("R1 tx raw", 8'h80);
    reg_check("R1 tx enable", 8'h88);

    // R2 raw set positions
    events(8'h01 << 3, 0, 8'h01 << 6, 0, 1, 0);
    reg_check("R2 tx raw bit3", 8'h80);
    reg_check("R2 rx raw bit6", 8'hA0);
    reg_check("R2 host err bit1", 8'hB0);
    check("R8 no irq while masked off", {31'b0, irq}, 32'h0);

    // R4 set with zeros unchanged
    reg_write(8'h88, 32'h0000_0009);
    reg_write(8'h88, 32'h0000_0020);
    reg_check("R4 tx enable", 8'h88);
    reg_check("R6 tx masked", 8'h84);
    reg_check("R6 enable via clear addr", 8'h8C);
    idle();
    check("R8 irq high", {31'b0, irq}, 32'h1);

    // R9 end of interrupt
    @(negedge clk);
    wr_en = 1; addr = 8'h94; wr_data = 32'h0;
    @(negedge clk);
    wr_en = 0;
    check("R9 irq low after eoi", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq reasserts", {31'b0, irq}, 32'h1);

    // R7 vector
    reg_write(8'hA8, 32'h0000_0040);
    reg_write(8'hB8, 32'h0000_0002);
    reg_check("R7 vector", 8'h90);
    reg_check("R6 error masked", 8'hB4);

    // R3 ack clears; simultaneous set wins
    events(0, 8'h08, 8'h40, 8'h40, 0, 1);
    reg_check("R3 tx ack clears", 8'h80);
    reg_check("R3 rx set beats ack", 8'hA0);
    reg_check("R3 host err ack", 8'hB0);

    // R5 clear all
    reg_write(8'hAC, 32'hFFFF_FFFF);
    reg_check("R5 rx enable cleared", 8'hA8);
    reg_write(8'h8C, 32'h0000_0001);
    reg_check("R5 tx clear keeps zeros", 8'h88);
    reg_write(8'h8C, 32'hFFFF_FFFF);
    reg_write(8'hBC, 32'hFFFF_FFFF);
    idle(); idle();
    check("R8 irq falls", {31'b0, irq}, 32'h0);

    // R10 unmapped
    reg_write(8'h40, 32'hFFFF_FFFF);
    reg_write(8'h80, 32'hFFFF_FFFF);
    reg_check("R10 unmapped read", 8'h40);
    reg_check("R10 raw not writable", 8'h80);
    reg_check("R10 enable unchanged", 8'h88);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] addrs [14] = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'h90, 8'hA0, 8'hA4,
                                 8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8, 8'hBC, 8'h50};
      case (op)
        0: events($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
        1: reg_write(addrs[$urandom_range(0, 12)] | 8'h08, $urandom);
        2: reg_write(addrs[$urandom_range(0, 12)] | 8'h0C, $urandom & 32'hFF);
        default: reg_write(addrs[$urandom_range(0, 12)] & 8'hF8 | 8'h08, $urandom);
      endcase
      ra = addrs[$urandom_range(0, 13)];
      reg_check("R6 random read", ra);
      check("R8 random irq", {31'b0, irq}, {31'b0, exp_irq()});
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule